// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block sits between a 32-bit control word and the handshake of a successive-approximation converter core. It divides the bus clock into an ADC function clock of hclk/(div+1). It also decides when each conversion begins. One of four start sources drives that decision: a software bit, a baseband RSSI request that is delayed by a programmable number of ADC clocks, a PCM voice-sampling mode that runs only while DMA is enabled, or an external timer strobe. A start is always aligned to the ADC clock edge that the control word picks. A started conversion carries the selected channel number (0 to 15) and a calibration flag to the core.

A conversion may be a single shot, or it may run continuously. In continuous mode each completion queues the next start for the following ADC clock edge. When the core reports done, the block latches the result into a data register and sets a sticky ready flag. If DMA is enabled it also raises a request that stays asserted until it is acknowledged.

Top module: `adc_trig_seq`

## Requirements
- R1: After a synchronous reset, conv_start_o, busy_o, ready_o and dma_req_o are 0 and data_o is 0.
- R2: adc_clk_o has a period of div+1 hclk cycles, where div is control bits [29:20].
- R3: Control bit 4 sets start alignment. With the bit at 1, conv_start_o pulses in the hclk cycle after adc_clk_o goes high. With the bit at 0, it pulses in the cycle after adc_clk_o goes low. This applies whenever div is 1 or more.
- R4: With source field [6:5] = 0, a 0-to-1 change of control bit 0 requests one conversion. A change that arrives while busy_o is 1 is discarded.
- R5: With source field = 1, a rising rssi_req_i loads the delay held in bits [13:8]. The start is issued on the (delay+1)-th rising edge of adc_clk_o after that. A new rising request while the delay is pending restarts the count.
- R6: With source field = 2, conversions start on their own only while DMA enable (bit 3) is 1 and the stop bit (bit 7) is 0.
- R7: A one-cycle tmr_trig_i pulse starts exactly one conversion when the source field = 3. The same pulse has no effect under any other source.
- R8: With bit 2 = 1, each done queues a new start for the next selected ADC edge. Clearing bit 2 stops the sequence once the current conversion ends.
- R9: core_done_i latches core_data_i into data_o and sets ready_o. ready_o stays 1 until a data_rd_i pulse.
- R10: When bit 3 is 1, done sets dma_req_o, which then holds until dma_ack_i. When bit 3 is 0, dma_req_o stays 0.
- R11: At each start, conv_chan_o takes chan_i and conv_cal_o takes control bit 1.
- R12: conv_start_o never pulses while a conversion is in progress. busy_o rises with the start and falls after core_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (hclk) |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 32 | Control word |
| chan_i | input | CH_W | Channel to convert |
| rssi_req_i | input | 1 | Baseband RSSI sample request |
| tmr_trig_i | input | 1 | External timer trigger strobe |
| core_done_i | input | 1 | Converter core finished |
| core_data_i | input | DATA_W | Converter core result |
| data_rd_i | input | 1 | Result read strobe, clears ready |
| dma_ack_i | input | 1 | DMA acknowledge |
| adc_clk_o | output | 1 | Divided ADC function clock |
| conv_start_o | output | 1 | One-cycle start pulse to the core |
| conv_chan_o | output | CH_W | Channel captured at start |
| conv_cal_o | output | 1 | Calibration flag captured at start |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | DATA_W | Latched result |
| ready_o | output | 1 | Sticky result-ready flag |
| dma_req_o | output | 1 | DMA request, held until acknowledged |

## Verification
The bench uses the default widths: a 10-bit divider field, a 6-bit delay, a 10-bit result and a 4-bit channel. Through the control word it sets divider values of 3 and 9, which lets it measure both ADC clock periods and both start alignments against a known counter phase. Delays of 2 and 3 ADC clocks, the second one restarted in the middle of its count, show where the RSSI start lands. A behavioural core with a long latency keeps the block busy long enough to show that late software starts are discarded and that continuous mode stops cleanly.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_RSSI = 2'd1,
    SRC_PCM  = 2'd2,
    SRC_TMR  = 2'd3
  } trig_src_e;

  localparam int B_SOC     = 0;
  localparam int B_CAL     = 1;
  localparam int B_CONT    = 2;
  localparam int B_DMA     = 3;
  localparam int B_EDGE    = 4;
  localparam int SRC_LSB   = 5;
  localparam int B_PCMSTOP = 7;
  localparam int DLY_LSB   = 8;
  localparam int DIV_LSB   = 20;
endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             adc_clk_o,
  output logic             rise_tk_o,
  output logic             fall_tk_o
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W-1:0] half;

  assign half    = div_i >> 1;
  assign cnt_nxt = (cnt >= div_i) ? '0 : cnt + DIV_W'(1);

  // counter starts at all ones so the first cycle out of reset is not an edge
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '1;
      adc_clk_o <= 1'b0;
    end else begin
      cnt       <= cnt_nxt;
      adc_clk_o <= (cnt_nxt <= half);
    end
  end

  assign rise_tk_o = (cnt == '0);
  assign fall_tk_o = (cnt == half + DIV_W'(1)) && (div_i != '0);

  AST_TICK_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_tk_o, fall_tk_o})); // R2
endmodule

// File: rtl/adc_rssi_delay.sv
module adc_rssi_delay #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             req_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o
);
  logic             req_q;
  logic             armed;
  logic [DLY_W-1:0] cnt;
  logic             req_rise;

  assign req_rise = req_i && !req_q;
  assign fire_o   = en_i && armed && tick_i && (cnt == '0) && !req_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      req_q <= req_i;
      if (!en_i) begin
        armed <= 1'b0;
      end else if (req_rise) begin
        armed <= 1'b1;
        cnt   <= dly_i;
      end else if (armed && tick_i) begin
        if (cnt == '0) armed <= 1'b0;
        else           cnt   <= cnt - DLY_W'(1);
      end
    end
  end

  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !armed); // R5
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_seq_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int DLY_W  = 6,
  parameter int DATA_W = 10,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       ctrl_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              rssi_req_i,
  input  logic              tmr_trig_i,
  input  logic              core_done_i,
  input  logic [DATA_W-1:0] core_data_i,
  input  logic              data_rd_i,
  input  logic              dma_ack_i,
  output logic              adc_clk_o,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_chan_o,
  output logic              conv_cal_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              dma_req_o
);
  trig_src_e        src;
  logic [DIV_W-1:0] div;
  logic [DLY_W-1:0] dly;
  logic             dma_en, cont_en, edge_rise, pcm_stop;
  logic             rise_tk, fall_tk, edge_tk;
  logic             rssi_fire;
  logic             sw_q, sw_rise;
  logic             pend_q, pend_set, pcm_ok, go;
  logic             unused_ctrl;

  assign src       = trig_src_e'(ctrl_i[SRC_LSB +: 2]);
  assign div       = ctrl_i[DIV_LSB +: DIV_W];
  assign dly       = ctrl_i[DLY_LSB +: DLY_W];
  assign dma_en    = ctrl_i[B_DMA];
  assign cont_en   = ctrl_i[B_CONT];
  assign edge_rise = ctrl_i[B_EDGE];
  assign pcm_stop  = ctrl_i[B_PCMSTOP];
  assign unused_ctrl = ^{ctrl_i[31:30], ctrl_i[19:14]};

  adc_clk_gen #(.DIV_W(DIV_W)) i_clk_gen (
    .clk       (clk),
    .rst       (rst),
    .div_i     (div),
    .adc_clk_o (adc_clk_o),
    .rise_tk_o (rise_tk),
    .fall_tk_o (fall_tk)
  );

  adc_rssi_delay #(.DLY_W(DLY_W)) i_rssi_dly (
    .clk    (clk),
    .rst    (rst),
    .en_i   (src == SRC_RSSI),
    .req_i  (rssi_req_i),
    .tick_i (rise_tk),
    .dly_i  (dly),
    .fire_o (rssi_fire)
  );

  assign edge_tk  = edge_rise ? rise_tk : fall_tk;
  assign sw_rise  = ctrl_i[B_SOC] && !sw_q;
  assign pend_set = !busy_o && ((src == SRC_SW && sw_rise) || (src == SRC_TMR && tmr_trig_i));
  assign pcm_ok   = (src == SRC_PCM) && dma_en && !pcm_stop;
  assign go       = (pend_q || rssi_fire || pcm_ok) && edge_tk && !busy_o;

  // start scheduling
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q         <= 1'b1;
      pend_q       <= 1'b0;
      busy_o       <= 1'b0;
      conv_start_o <= 1'b0;
      conv_chan_o  <= '0;
      conv_cal_o   <= 1'b0;
    end else begin
      sw_q         <= ctrl_i[B_SOC];
      conv_start_o <= go;
      if (go) pend_q <= 1'b0;
      else    pend_q <= pend_q || pend_set || rssi_fire || (core_done_i && cont_en);
      if (go) begin
        busy_o      <= 1'b1;
        conv_chan_o <= chan_i;
        conv_cal_o  <= ctrl_i[B_CAL];
      end else if (core_done_i) begin
        busy_o <= 1'b0;
      end
    end
  end

  // result capture
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      ready_o   <= 1'b0;
      dma_req_o <= 1'b0;
    end else begin
      if (core_done_i) data_o <= core_data_i;
      if (core_done_i)    ready_o <= 1'b1;
      else if (data_rd_i) ready_o <= 1'b0;
      if (core_done_i && dma_en) dma_req_o <= 1'b1;
      else if (dma_ack_i)        dma_req_o <= 1'b0;
    end
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |-> !$past(busy_o) && busy_o); // R12
  AST_RISE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    conv_start_o && $past(edge_rise) && ($past(div) != '0) |->
      $past(adc_clk_o) && !$past(adc_clk_o, 2)); // R3
  AST_FALL_ALIGN: assert property (@(posedge clk) disable iff (rst)
    conv_start_o && !$past(edge_rise) && ($past(div) != '0) |->
      !$past(adc_clk_o) && $past(adc_clk_o, 2)); // R3
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready_o && !data_rd_i |=> ready_o); // R9
  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (rst)
    dma_req_o && !dma_ack_i |=> dma_req_o); // R10
endmodule

// File: tb/test_adc_trig_seq.sv
`timescale 1ns/1ps
module test_adc_trig_seq;
  localparam logic [31:0] BASE = 32'h003B0010;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctrl = BASE;
  logic [3:0]  chan_i = '0;
  logic        rssi_req_i = 1'b0, tmr_trig_i = 1'b0;
  logic        core_done_i = 1'b0;
  logic [9:0]  core_data_i = '0;
  logic        data_rd_i = 1'b0, dma_ack_i = 1'b0;
  logic        adc_clk_o, conv_start_o, conv_cal_o, busy_o, ready_o, dma_req_o;
  logic [3:0]  conv_chan_o;
  logic [9:0]  data_o;

  int checks = 0, errors = 0;
  int cyc = 0, n_rise = 0, last_rise = 0, rise_period = 0;
  int n_start = 0, rise_at_start = 0, core_lat = 3, lat_cnt = 0;
  bit h1 = 0, h2 = 0, rel_rise = 0, rel_fall = 0, finished = 0;

  always #10 clk = ~clk;

  adc_trig_seq i_adc_trig_seq (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .chan_i(chan_i),
    .rssi_req_i(rssi_req_i), .tmr_trig_i(tmr_trig_i),
    .core_done_i(core_done_i), .core_data_i(core_data_i),
    .data_rd_i(data_rd_i), .dma_ack_i(dma_ack_i),
    .adc_clk_o(adc_clk_o), .conv_start_o(conv_start_o), .conv_chan_o(conv_chan_o),
    .conv_cal_o(conv_cal_o), .busy_o(busy_o), .data_o(data_o),
    .ready_o(ready_o), .dma_req_o(dma_req_o)
  );

  // monitor and behavioural converter core, both on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (adc_clk_o && !h1) begin
        rise_period = cyc - last_rise;
        last_rise = cyc;
        n_rise++;
      end
      if (conv_start_o) begin
        n_start++;
        rise_at_start = n_rise;
        rel_rise = h1 && !h2;
        rel_fall = !h1 && h2;
      end
    end
    h2 = h1;
    h1 = adc_clk_o;
    core_done_i = 1'b0;
    if (lat_cnt != 0) begin
      lat_cnt--;
      if (lat_cnt == 0) core_done_i = 1'b1;
    end
    if (conv_start_o) lat_cnt = core_lat;
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start(input int target, input int lim);
    for (int i = 0; i < lim && n_start < target; i++) tick();
  endtask

  task automatic pulse_sw();
    ctrl[0] = 1'b1; tick(); ctrl[0] = 1'b0; tick();
  endtask

  task automatic align_rise();
    int r0;
    r0 = n_rise;
    for (int i = 0; i < 40 && n_rise == r0; i++) tick();
  endtask

  // {channel, data, rising edge, calibration}
  localparam logic [15:0] VEC [4] = '{
    {4'd5,  10'h2A5, 1'b1, 1'b0},
    {4'd15, 10'h15A, 1'b0, 1'b1},
    {4'd0,  10'h3FF, 1'b0, 1'b0},
    {4'd9,  10'h001, 1'b1, 1'b1}
  };

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0, s1, base;
    repeat (3) tick();
    // R1 reset values
    chk(!conv_start_o && !busy_o, "R1 start/busy", {conv_start_o, busy_o}, 0);
    chk(!ready_o && !dma_req_o && data_o == 0, "R1 ready/dma/data", data_o, 0);
    rst = 1'b0;
    repeat (20) tick();
    chk(rise_period == 4, "R2 period div3", rise_period, 4);

    // vector walk of software starts
    for (int k = 0; k < 4; k++) begin
      chan_i = VEC[k][15:12];
      core_data_i = VEC[k][11:2];
      ctrl[4] = VEC[k][1];
      ctrl[1] = VEC[k][0];
      s0 = n_start;
      pulse_sw();
      wait_start(s0 + 1, 40);
      chk(n_start == s0 + 1, "R4 sw start", n_start - s0, 1);
      chk(VEC[k][1] ? rel_rise : rel_fall, "R3 edge align", VEC[k][1] ? rel_rise : rel_fall, 1);
      chk(conv_chan_o == VEC[k][15:12], "R11 channel", conv_chan_o, VEC[k][15:12]);
      chk(conv_cal_o == VEC[k][0], "R11 cal", conv_cal_o, VEC[k][0]);
      for (int i = 0; i < 20 && !ready_o; i++) tick();
      chk(data_o == VEC[k][11:2], "R9 data", data_o, VEC[k][11:2]);
      chk(!dma_req_o, "R10 no dma when disabled", dma_req_o, 0);
      repeat (5) tick();
      chk(ready_o, "R9 ready sticky", ready_o, 1);
      data_rd_i = 1'b1; tick(); data_rd_i = 1'b0;
      chk(!ready_o, "R9 ready cleared", ready_o, 0);
    end
    ctrl = BASE;

    // R4 / R12: software start while busy is discarded
    core_lat = 40;
    s0 = n_start;
    ctrl[0] = 1'b1;
    wait_start(s0 + 1, 40);
    ctrl[0] = 1'b0; tick(); ctrl[0] = 1'b1; tick();
    chk(busy_o, "R12 busy during conversion", busy_o, 1);
    repeat (80) tick();
    chk(n_start == s0 + 1, "R4 start ignored while busy", n_start - s0, 1);
    chk(!busy_o, "R12 busy falls after done", busy_o, 0);
    ctrl[0] = 1'b0; tick();
    core_lat = 3;

    // R8 continuous mode
    ctrl[2] = 1'b1;
    s0 = n_start;
    pulse_sw();
    repeat (60) tick();
    chk(n_start - s0 >= 5, "R8 continuous repeats", n_start - s0, 5);
    ctrl[2] = 1'b0;
    repeat (20) tick();
    s1 = n_start;
    repeat (40) tick();
    chk(n_start == s1, "R8 continuous stops", n_start - s1, 0);

    // R7 timer trigger
    ctrl[6:5] = 2'd3;
    s0 = n_start;
    tmr_trig_i = 1'b1; tick(); tmr_trig_i = 1'b0;
    repeat (20) tick();
    chk(n_start == s0 + 1, "R7 timer start", n_start - s0, 1);
    ctrl[6:5] = 2'd0;
    s0 = n_start;
    tmr_trig_i = 1'b1; tick(); tmr_trig_i = 1'b0;
    repeat (30) tick();
    chk(n_start == s0, "R7 timer ignored in sw source", n_start - s0, 0);

    // R6 PCM mode
    ctrl[6:5] = 2'd2;
    s0 = n_start;
    repeat (40) tick();
    chk(n_start == s0, "R6 pcm needs dma", n_start - s0, 0);
    ctrl[3] = 1'b1;
    repeat (40) tick();
    chk(n_start - s0 >= 3, "R6 pcm runs with dma", n_start - s0, 3);
    ctrl[7] = 1'b1;
    repeat (20) tick();
    s1 = n_start;
    repeat (40) tick();
    chk(n_start == s1, "R6 pcm stop bit", n_start - s1, 0);
    ctrl = BASE;
    dma_ack_i = 1'b1; tick(); dma_ack_i = 1'b0;
    data_rd_i = 1'b1; tick(); data_rd_i = 1'b0;
    chk(!dma_req_o, "R10 dma acked", dma_req_o, 0);

    // R10 dma hold until ack
    ctrl[3] = 1'b1;
    pulse_sw();
    for (int i = 0; i < 40 && !dma_req_o; i++) tick();
    repeat (10) tick();
    chk(dma_req_o, "R10 dma held", dma_req_o, 1);
    dma_ack_i = 1'b1; tick(); dma_ack_i = 1'b0;
    chk(!dma_req_o, "R10 dma released", dma_req_o, 0);
    ctrl = BASE;
    repeat (10) tick();

    // R5 RSSI delay of 2
    ctrl[6:5] = 2'd1;
    ctrl[13:8] = 6'd2;
    align_rise();
    base = n_rise;
    s0 = n_start;
    rssi_req_i = 1'b1;
    wait_start(s0 + 1, 60);
    chk(rise_at_start - base == 3, "R5 rssi delay 2", rise_at_start - base, 3);
    rssi_req_i = 1'b0;
    repeat (20) tick();

    // R5 restart of a pending delay of 3
    ctrl[13:8] = 6'd3;
    align_rise();
    s0 = n_start;
    rssi_req_i = 1'b1;
    align_rise();
    rssi_req_i = 1'b0; tick();
    base = n_rise;
    rssi_req_i = 1'b1;
    wait_start(s0 + 1, 80);
    chk(rise_at_start - base == 4, "R5 rssi restart", rise_at_start - base, 4);
    rssi_req_i = 1'b0;
    ctrl = BASE;
    repeat (20) tick();

    // R2 divider of 9
    ctrl[29:20] = 10'd9;
    repeat (40) tick();
    chk(rise_period == 10, "R2 period div9", rise_period, 10);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule